// File: doc/BRIEF.md
# Trigger-Aligned Channel Readout and Math Engine

The engine reads a stored capture out of per-channel circular buffers in time order, starting at a word offset inside the ring. The caller picks that offset from the trigger record, so that pre-trigger samples appear first. Two independent read pointers follow the same offset sequence, one in each of two chosen channel regions. Each packed memory word passes through a per-lane arithmetic stage. That stage can copy channel A unchanged, or it can form the saturating sum or the saturating product of the two channels.

The results leave as a write-back stream of words, flagged with valid and last, for a memory writer downstream. When the sample count is not a whole number of words, the final word carries only the leading samples. The unused lanes are zeroed and their byte-enables are dropped. Backpressure on the write-back side freezes both read pointers together.

The memory is seen through two asynchronous read ports. A global word address goes out, and the word at that address comes back in the same cycle. Channel `c` occupies word addresses `c*REGION_WORDS` up to `c*REGION_WORDS + REGION_WORDS - 1`.

Top module: `trig_readout`

## Requirements
- R1: After reset, `busy_o`, `wb_valid_o` and `wb_last_o` are 0.
- R2: `start_i` is accepted only when `busy_o` is 0 and `sample_cnt_i` is non-zero; it latches `chan_a_i`, `chan_b_i`, `op_i`, `start_off_i` and `sample_cnt_i`. A start with zero count, or one raised while busy, has no effect on the stream or on `busy_o`.
- R3: Output word k is built from region offset `(start_off_i + k) mod REGION_WORDS` of each selected channel. The pointer wraps from the region's last word to its first word, within the same channel.
- R4: A request yields `ceil(sample_cnt_i / LANES)` words. `wb_last_o` is 1 on the final word only. After the final word is accepted, the stream goes idle and `busy_o` returns to 0.
- R5: Lane i occupies bits `[i*SAMPLE_W +: SAMPLE_W]`, with the earliest sample in lane 0. Byte-enable bit j covers data byte j. On the final word, when `sample_cnt_i mod LANES` is t ≠ 0, lanes t and above are zero with byte-enables 0. All other words have every byte-enable set.
- R6: `op_i` encoding: 0 and 3 copy channel A unchanged, 1 gives the sum, 2 gives the product. All operations are unsigned and work lane by lane.
- R7: A sum above `2**SAMPLE_W - 1` saturates to `2**SAMPLE_W - 1`.
- R8: A product above `2**SAMPLE_W - 1` saturates to `2**SAMPLE_W - 1`.
- R9: While `wb_valid_o` is 1 and `wb_ready_i` is 0, the output word, byte-enables, last flag and both read addresses hold for the next cycle.
- R10: The two read pointers are independent. Any pair of channels, the same channel twice included, can be combined. One cycle after a start is accepted, `rd_addr_a_o` and `rd_addr_b_o` show `chan*REGION_WORDS + start_off`.
- R11: `rd_data_a_i` and `rd_data_b_i` are taken as the words at the current read addresses in the same cycle. A word appears on `wb_data_o` on the clock edge after its address was presented, provided the output register is free or being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| chan_a_i | input | CH_W | First source channel |
| chan_b_i | input | CH_W | Second source channel |
| op_i | input | 2 | Operation code |
| start_off_i | input | OFF_W | Trigger-corrected start word offset in the ring |
| sample_cnt_i | input | CNT_W | Samples to read |
| busy_o | output | 1 | Request in progress or word pending |
| rd_addr_a_o | output | AW | Read address, pointer A |
| rd_data_a_i | input | WORD_W | Read data, pointer A |
| rd_addr_b_o | output | AW | Read address, pointer B |
| rd_data_b_i | input | WORD_W | Read data, pointer B |
| wb_valid_o | output | 1 | Write-back word valid |
| wb_ready_i | input | 1 | Write-back sink ready |
| wb_data_o | output | WORD_W | Write-back word |
| wb_be_o | output | BE_W | Write-back byte-enables |
| wb_last_o | output | 1 | Final word of the request |

## Verification
The bench uses the defaults: four channels, 16-word regions, and four 8-bit lanes per word. With these values a ring wrap is reachable from short requests, every tail length from one to four lanes occurs, and a 64-sample request sweeps a full region from a mid-ring offset. The 8-bit lanes let small operand values cross the saturation bound for both sum and product. Random ready patterns make stalls land on any word, the final one included.

// File: rtl/trig_readout_pkg.sv
package trig_readout_pkg;
  typedef enum logic [1:0] {
    OP_PASS     = 2'd0,
    OP_SUM      = 2'd1,
    OP_MUL      = 2'd2,
    OP_PASS_ALT = 2'd3
  } op_e;
endpackage

// File: rtl/rd_ptr.sv
module rd_ptr #(
  parameter int NUM_CH       = 4,
  parameter int REGION_WORDS = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int OFF_W = $clog2(REGION_WORDS),
  localparam int AW    = $clog2(NUM_CH * REGION_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             adv_i,
  output logic [AW-1:0]    addr_o
);
  logic [CH_W-1:0]  chan_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      chan_q <= chan_i;
      off_q  <= off_i;
    end else if (adv_i) begin
      off_q <= (off_q == OFF_W'(REGION_WORDS - 1)) ? '0 : off_q + 1'b1;
    end
  end

  assign addr_o = AW'(chan_q) * AW'(REGION_WORDS) + AW'(off_q);
endmodule

// File: rtl/lane_math.sv
module lane_math
  import trig_readout_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] a_i,
  input  logic [SAMPLE_W-1:0] b_i,
  input  op_e                 op_i,
  input  logic                keep_i,
  output logic [SAMPLE_W-1:0] y_o
);
  logic [SAMPLE_W:0]     sum;
  logic [2*SAMPLE_W-1:0] prod;
  logic [SAMPLE_W-1:0]   res;

  assign sum  = {1'b0, a_i} + {1'b0, b_i};
  assign prod = a_i * b_i;

  always_comb begin
    unique case (op_i)
      OP_SUM:  res = sum[SAMPLE_W] ? '1 : sum[SAMPLE_W-1:0];
      OP_MUL:  res = (|prod[2*SAMPLE_W-1:SAMPLE_W]) ? '1 : prod[SAMPLE_W-1:0];
      default: res = a_i;
    endcase
  end

  assign y_o = keep_i ? res : '0;
endmodule

// File: rtl/trig_readout.sv
module trig_readout
  import trig_readout_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int REGION_WORDS = 16,
  parameter int LANES        = 4,
  parameter int SAMPLE_W     = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int OFF_W  = $clog2(REGION_WORDS),
  localparam int AW     = $clog2(NUM_CH * REGION_WORDS),
  localparam int WORD_W = LANES * SAMPLE_W,
  localparam int BE_W   = WORD_W / 8,
  localparam int CNT_W  = $clog2(REGION_WORDS * LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_a_i,
  input  logic [CH_W-1:0]   chan_b_i,
  input  logic [1:0]        op_i,
  input  logic [OFF_W-1:0]  start_off_i,
  input  logic [CNT_W-1:0]  sample_cnt_i,
  output logic              busy_o,
  output logic [AW-1:0]     rd_addr_a_o,
  input  logic [WORD_W-1:0] rd_data_a_i,
  output logic [AW-1:0]     rd_addr_b_o,
  input  logic [WORD_W-1:0] rd_data_b_i,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [WORD_W-1:0] wb_data_o,
  output logic [BE_W-1:0]   wb_be_o,
  output logic              wb_last_o
);
  localparam int LANE_W  = $clog2(LANES);
  localparam int WCNT_W  = $clog2(REGION_WORDS + 1);
  localparam int BPL     = SAMPLE_W / 8;

  logic              run_q;
  logic [WCNT_W-1:0] words_q;
  logic [LANE_W-1:0] tail_q;
  op_e               op_q;
  logic              accept, adv, is_last;
  logic [CNT_W:0]    cnt_round;
  logic [LANES-1:0]  keep;
  logic [WORD_W-1:0] word_nxt;
  logic [BE_W-1:0]   be_nxt;

  assign accept    = start_i && !run_q && !wb_valid_o && (sample_cnt_i != '0);
  assign adv       = run_q && (!wb_valid_o || wb_ready_i);
  assign is_last   = (words_q == WCNT_W'(1));
  assign cnt_round = {1'b0, sample_cnt_i} + (CNT_W + 1)'(LANES - 1);
  assign busy_o    = run_q || wb_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      words_q <= '0;
      tail_q  <= '0;
      op_q    <= OP_PASS;
    end else if (accept) begin
      run_q   <= 1'b1;
      words_q <= WCNT_W'(cnt_round >> LANE_W);
      tail_q  <= sample_cnt_i[LANE_W-1:0];
      op_q    <= op_e'(op_i);
    end else if (adv) begin
      words_q <= words_q - 1'b1;
      if (is_last) run_q <= 1'b0;
    end
  end

  rd_ptr #(.NUM_CH(NUM_CH), .REGION_WORDS(REGION_WORDS)) u_ptr_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .chan_i(chan_a_i),
    .off_i(start_off_i), .adv_i(adv), .addr_o(rd_addr_a_o)
  );

  rd_ptr #(.NUM_CH(NUM_CH), .REGION_WORDS(REGION_WORDS)) u_ptr_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .chan_i(chan_b_i),
    .off_i(start_off_i), .adv_i(adv), .addr_o(rd_addr_b_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // tail lanes of a partial final word are blanked
    assign keep[l] = !(is_last && (tail_q != '0) && (LANE_W'(l) >= tail_q));
    assign be_nxt[l*BPL +: BPL] = {BPL{keep[l]}};
    lane_math #(.SAMPLE_W(SAMPLE_W)) u_math (
      .a_i   (rd_data_a_i[l*SAMPLE_W +: SAMPLE_W]),
      .b_i   (rd_data_b_i[l*SAMPLE_W +: SAMPLE_W]),
      .op_i  (op_q),
      .keep_i(keep[l]),
      .y_o   (word_nxt[l*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_data_o  <= '0;
      wb_be_o    <= '0;
      wb_last_o  <= 1'b0;
    end else if (adv) begin
      wb_valid_o <= 1'b1;
      wb_data_o  <= word_nxt;
      wb_be_o    <= be_nxt;
      wb_last_o  <= is_last;
    end else if (wb_ready_i) begin
      wb_valid_o <= 1'b0;
      wb_last_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_readout_chk.sv
module trig_readout_chk #(
  parameter int NUM_CH       = 4,
  parameter int REGION_WORDS = 16,
  parameter int LANES        = 4,
  parameter int SAMPLE_W     = 8,
  localparam int AW     = $clog2(NUM_CH * REGION_WORDS),
  localparam int WORD_W = LANES * SAMPLE_W,
  localparam int BE_W   = WORD_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic [AW-1:0]     rd_addr_a_o,
  input logic [AW-1:0]     rd_addr_b_o,
  input logic              wb_valid_o,
  input logic              wb_ready_i,
  input logic [WORD_W-1:0] wb_data_o,
  input logic [BE_W-1:0]   wb_be_o,
  input logic              wb_last_o
);
  logic [WORD_W-1:0] be_mask;
  for (genvar j = 0; j < BE_W; j++) begin : g_mask
    assign be_mask[j*8 +: 8] = {8{wb_be_o[j]}};
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_data_o) && $stable(wb_be_o)
      && $stable(wb_last_o) && $stable(rd_addr_a_o) && $stable(rd_addr_b_o));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && !$stable(rd_addr_a_o)
      && (int'($past(rd_addr_a_o)) % REGION_WORDS == REGION_WORDS - 1)
    |-> int'(rd_addr_a_o) == int'($past(rd_addr_a_o)) - (REGION_WORDS - 1));

  p_full_be_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_last_o |-> &wb_be_o);

  p_lane0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_be_o[0]);

  p_mask_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_data_o & ~be_mask) == '0);

  p_last_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && wb_last_o && wb_ready_i |=> !wb_valid_o);
endmodule

bind trig_readout trig_readout_chk #(
  .NUM_CH(NUM_CH), .REGION_WORDS(REGION_WORDS), .LANES(LANES), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o),
  .rd_addr_a_o(rd_addr_a_o), .rd_addr_b_o(rd_addr_b_o),
  .wb_valid_o(wb_valid_o), .wb_ready_i(wb_ready_i), .wb_data_o(wb_data_o),
  .wb_be_o(wb_be_o), .wb_last_o(wb_last_o)
);

// File: tb/sim_trig_readout.sv
`timescale 1ns/1ps
module sim_trig_readout;
  localparam int NCH = 4, RW = 16, LN = 4, SW = 8;
  localparam int WW = LN * SW, AWB = 6, BEW = WW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b0;
  logic [1:0] ca = '0, cb = '0, op = '0;
  logic [3:0] soff = '0;
  logic [6:0] cnt = '0;
  logic busy, wv, wl;
  logic [AWB-1:0] aa, ab;
  logic [WW-1:0] da, db, wd;
  logic [BEW-1:0] wbe;
  logic [WW-1:0] mem [NCH*RW];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign da = mem[aa];
  assign db = mem[ab];

  trig_readout u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_a_i(ca), .chan_b_i(cb),
    .op_i(op), .start_off_i(soff), .sample_cnt_i(cnt), .busy_o(busy),
    .rd_addr_a_o(aa), .rd_data_a_i(da), .rd_addr_b_o(ab), .rd_data_b_i(db),
    .wb_valid_o(wv), .wb_ready_i(ready), .wb_data_o(wd), .wb_be_o(wbe), .wb_last_o(wl)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] lane_op(input logic [SW-1:0] a, input logic [SW-1:0] b, input int o);
    int r;
    case (o)
      1: r = int'(a) + int'(b);
      2: r = int'(a) * int'(b);
      default: r = int'(a);
    endcase
    return (r > 255) ? 8'hff : SW'(r);
  endfunction

  function automatic logic [WW-1:0] exp_data(input int c0, input int c1, input int o, input int off, input int n, input int k);
    logic [WW-1:0] w = '0;
    int nw = (n + LN - 1) / LN;
    int t = n % LN;
    int ro = (off + k) % RW;
    for (int l = 0; l < LN; l++)
      if (!(k == nw - 1 && t != 0 && l >= t))
        w[l*SW +: SW] = lane_op(mem[c0*RW+ro][l*SW +: SW], mem[c1*RW+ro][l*SW +: SW], o);
    return w;
  endfunction

  function automatic logic [BEW-1:0] exp_be(input int n, input int k);
    logic [BEW-1:0] b = '1;
    int nw = (n + LN - 1) / LN;
    int t = n % LN;
    if (k == nw - 1 && t != 0)
      for (int l = 0; l < LN; l++) if (l >= t) b[l] = 1'b0;
    return b;
  endfunction

  // one request; ready_pct sets random stall density; poke issues a stray start mid-run (R2)
  task automatic run_txn(input int c0, input int c1, input int o, input int off, input int n,
                         input int ready_pct, input bit poke, input string tag);
    int nw = (n + LN - 1) / LN;
    int k = 0;
    int guard = 0;
    @(negedge clk);
    ca = 2'(c0); cb = 2'(c1); op = 2'(o); soff = 4'(off); cnt = 7'(n); start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(aa == AWB'(c0*RW+off), {tag, " R10 addr a"}, 64'(aa), 64'(c0*RW+off));
    check(ab == AWB'(c1*RW+off), {tag, " R10 addr b"}, 64'(ab), 64'(c1*RW+off));
    while (k < nw && guard < 2000) begin
      guard++;
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 1) begin
        start = 1'b1; ca = 2'(c0 + 1); cb = 2'(c1 + 2); op = 2'(o + 1); soff = 4'(off + 5); cnt = 7'd3;
      end
      ready = (($urandom % 100) < ready_pct);
      if (wv && ready) begin
        check(wd == exp_data(c0, c1, o, off, n, k), {tag, " R3 R6 data"}, 64'(wd), 64'(exp_data(c0, c1, o, off, n, k)));
        check(wbe == exp_be(n, k), {tag, " R5 be"}, 64'(wbe), 64'(exp_be(n, k)));
        check(wl == (k == nw - 1), {tag, " R4 last"}, 64'(wl), 64'(k == nw - 1));
        k++;
      end
    end
    check(k == nw, {tag, " R4 word count"}, 64'(k), 64'(nw));
    @(negedge clk);
    start = 1'b0; ready = 1'b0;
    check(!busy && !wv, {tag, " R4 idle after last"}, 64'({busy, wv}), 64'(0));
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NCH*RW; i++) mem[i] = $urandom;
    #12 rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !wv && !wl, "R1 reset state", 64'({busy, wv, wl}), 64'(0));

    // saturation directed words: A lanes {0,15,16,200}, B lanes {9,17,16,100}
    mem[0*RW+0] = {8'd0, 8'd15, 8'd16, 8'd200};
    mem[1*RW+0] = {8'd9, 8'd17, 8'd16, 8'd100};
    run_txn(0, 1, 1, 0, 4, 100, 0, "R7 sum saturate");
    run_txn(0, 1, 2, 0, 4, 100, 0, "R8 product saturate");
    run_txn(0, 1, 0, 0, 4, 100, 0, "R6 pass");
    run_txn(0, 1, 3, 0, 4, 100, 0, "R6 pass alt");
    run_txn(2, 2, 1, 15, 64, 60, 0, "R3 full ring wrap");
    run_txn(3, 0, 2, 14, 9, 50, 0, "R5 tail1 wrap");
    run_txn(1, 3, 1, 7, 1, 100, 0, "R5 single sample");
    run_txn(1, 2, 0, 3, 11, 30, 1, "R2 R9 start while busy");

    // zero count ignored
    @(negedge clk);
    cnt = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy && !wv, "R2 zero count ignored", 64'({busy, wv}), 64'(0));

    for (int t = 0; t < 40; t++)
      run_txn(int'($urandom % NCH), int'($urandom % NCH), int'($urandom % 4),
              int'($urandom % RW), 1 + int'($urandom % (RW*LN)), 40 + int'($urandom % 60), 0, "R11 random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule